// File: doc/BRIEF.md
# Transmit Frame Byte Sequencer

This block orders the bytes of one outgoing frame on a single-wire control bus. A frame is a header byte followed by 0 to 15 payload bytes. A header with no payload is a ping. The sequencer builds the header from a 4-bit initiator address and a 4-bit destination address. It presents one byte at a time to a bit-level transmitter, and it tells that transmitter which byte is the final one.

Software begins a frame by writing the start control bit. It supplies each payload byte through a one-byte data holding register, in answer to a byte-request flag. It marks the final byte by setting an end-of-message bit while that byte is the one on offer. For a ping, the end bit must be set before the start bit. The bit transmitter returns three kinds of event:

- a load strobe when it needs the next byte;
- a per-byte done strobe with the acknowledge result;
- arbitration-lost and transmit-error events.

The sequencer converts these events into six sticky flags, each cleared by writing one, and an interrupt line gated by per-flag enables.

Top module: `txseq_top`

## Requirements
- R1: The header byte offered after a frame starts is initiator address in bits 7:4 and destination address in bits 3:0.
- R2: A start write while idle sets busy from the next cycle and offers the header. A start write while busy has no effect on the byte on offer or on busy.
- R3: When a byte that is not the final byte is taken by a load strobe, flag bit 0 (byte request) is set. A data write fills the holding register and clears the byte request.
- R4: The end-of-message bit marks the byte on offer at the time as final (tx_last). The bit is cleared when that byte is taken. If the bit is set before start, the frame is a ping: the header is final.
- R5: The 15th payload byte is always offered as final, even when the end-of-message bit is clear.
- R6: A load strobe after the header while the holding register is empty sets flag bit 2 (underrun) and ends the frame (busy falls) without setting completion.
- R7: A done strobe on the final byte sets flag bit 1 (completion) and clears busy. This requires a positive acknowledge, except for the broadcast destination 4'hF, where the acknowledge value is not checked.
- R8: A done strobe without acknowledge on any byte of a non-broadcast frame sets flag bit 4 (missing acknowledge) and ends the frame without completion.
- R9: During a frame, an arbitration-lost event sets flag bit 5 and a transmit-error event sets flag bit 3. Either event ends the frame.
- R10: Writing one to a flag bit clears it. The interrupt output is the OR of the flags masked by the enable vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_wr | input | 1 | Write one to the start-of-frame control bit |
| end_wr | input | 1 | Write one to the end-of-message control bit |
| data_wr | input | 1 | Write strobe for the data holding register |
| data_in | input | 8 | Payload byte to hold |
| init_addr | input | 4 | Initiator logical address |
| dest_addr | input | 4 | Destination logical address (4'hF is broadcast) |
| flag_clr | input | 6 | Write-one-to-clear mask for the flags |
| irq_en | input | 6 | Per-flag interrupt enables |
| bt_load | input | 1 | Bit transmitter takes the byte on offer |
| bt_done | input | 1 | Bit transmitter finished a byte |
| bt_ack | input | 1 | Acknowledge result that goes with bt_done |
| bt_arb_lost | input | 1 | Arbitration lost on the line |
| bt_err | input | 1 | General transmit error |
| tx_avail | output | 1 | A byte is on offer to the bit transmitter |
| tx_byte | output | 8 | Byte on offer |
| tx_last | output | 1 | Byte on offer is the final byte |
| busy | output | 1 | Start bit readback: a frame is in progress |
| eom_pending | output | 1 | End-of-message bit readback |
| flags | output | 6 | Sticky flags: 0 request, 1 completion, 2 underrun, 3 error, 4 missing ack, 5 arbitration lost |
| irq | output | 1 | Interrupt |

## Verification
Frames are swept over every payload length from 0 to 15, each with its own initiator, destination and payload values. This separates correct header packing, byte order and final-byte marking from off-by-one errors in the payload counter. A 15-byte frame with the end bit never set exercises the forced final byte, kept apart from the end-bit path. Broadcast frames without acknowledge are run beside unicast frames without acknowledge, to show that only the unicast frames abort. Separate short frames provoke underrun, arbitration loss, transmit error and a repeated start, and each must leave exactly its own flag and a cleared busy.

// File: rtl/txseq_pkg.sv
package txseq_pkg;
   localparam int FLG_REQ  = 0;
   localparam int FLG_END  = 1;
   localparam int FLG_UDR  = 2;
   localparam int FLG_ERR  = 3;
   localparam int FLG_NACK = 4;
   localparam int FLG_ARB  = 5;
   localparam int FLG_N    = 6;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_FINAL = 2'd2
   } seq_state_t;
endpackage

// File: rtl/txseq_flag_bank.sv
module txseq_flag_bank #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   input  logic [N-1:0] en_i,
   output logic [N-1:0] flag_o,
   output logic         irq_o
);
   if (N < 1) begin : g_bad_n
      $error("txseq_flag_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flag_o[i] <= 1'b0;
         else if (set_i[i])
            flag_o[i] <= 1'b1;
         else if (clr_i[i])
            flag_o[i] <= 1'b0;
      end

      // R10: a clear with no competing set empties the flag
      p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
      p_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flag_o[i]);
   end

   assign irq_o = |(flag_o & en_i);
endmodule

// File: rtl/txseq_fsm.sv
module txseq_fsm
   import txseq_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int MAX_PAYLOAD = 15,
   localparam int CNT_W      = $clog2(MAX_PAYLOAD + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_wr,
   input  logic              end_wr,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_in,
   input  logic [ADDR_W-1:0] init_addr,
   input  logic [ADDR_W-1:0] dest_addr,
   input  logic              load_i,
   input  logic              done_i,
   input  logic              ack_i,
   input  logic              arb_i,
   input  logic              err_i,
   output logic              tx_avail,
   output logic [DATA_W-1:0] tx_byte,
   output logic              tx_last,
   output logic              busy,
   output logic              eom_o,
   output logic [FLG_N-1:0]  flag_set
);
   localparam logic [ADDR_W-1:0] BCAST    = {ADDR_W{1'b1}};
   localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(MAX_PAYLOAD - 1);

   if (DATA_W != 2 * ADDR_W) begin : g_bad_width
      $error("txseq_fsm: DATA_W must hold two addresses");
   end
   if (MAX_PAYLOAD < 1) begin : g_bad_max
      $error("txseq_fsm: MAX_PAYLOAD must be at least 1");
   end

   seq_state_t        state;
   logic              hdr_sent;
   logic              buf_valid;
   logic [DATA_W-1:0] buf_data;
   logic              eom_bit;
   logic [CNT_W-1:0]  pay_cnt;

   logic active, take, under, good_take, ev_arb, ev_err, nack_bad, fin, abort;
   logic force_last;

   assign active     = (state != ST_IDLE);
   assign force_last = hdr_sent && (pay_cnt == LAST_IDX);
   assign tx_avail   = (state == ST_RUN) && (!hdr_sent || buf_valid);
   assign tx_byte    = hdr_sent ? buf_data : {init_addr, dest_addr};
   assign tx_last    = eom_bit || force_last;
   assign busy       = active;
   assign eom_o      = eom_bit;

   assign take      = (state == ST_RUN) && load_i;
   assign under     = take && hdr_sent && !buf_valid;
   assign ev_arb    = active && arb_i;
   assign ev_err    = active && err_i && !ev_arb;
   assign nack_bad  = active && done_i && !ack_i && (dest_addr != BCAST)
                      && !ev_arb && !ev_err;
   assign good_take = take && !under && !ev_arb && !ev_err && !nack_bad;
   assign fin       = (state == ST_FINAL) && done_i && !ev_arb && !ev_err && !nack_bad;
   assign abort     = ev_arb || ev_err || nack_bad || (under && !ev_arb && !ev_err && !nack_bad);

   always_comb begin
      flag_set           = '0;
      flag_set[FLG_REQ]  = good_take && !tx_last;
      flag_set[FLG_END]  = fin;
      flag_set[FLG_UDR]  = under && !ev_arb && !ev_err && !nack_bad;
      flag_set[FLG_ERR]  = ev_err;
      flag_set[FLG_NACK] = nack_bad;
      flag_set[FLG_ARB]  = ev_arb;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         hdr_sent <= 1'b0;
         pay_cnt  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start_wr) begin
               state    <= ST_RUN;
               hdr_sent <= 1'b0;
               pay_cnt  <= '0;
            end
            ST_RUN: if (abort) begin
               state <= ST_IDLE;
            end else if (good_take) begin
               hdr_sent <= 1'b1;
               if (hdr_sent) pay_cnt <= pay_cnt + 1'b1;
               if (tx_last) state <= ST_FINAL;
            end
            ST_FINAL: if (abort || fin) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_valid <= 1'b0;
         buf_data  <= '0;
      end else if (data_wr) begin
         buf_valid <= 1'b1;
         buf_data  <= data_in;
      end else if ((good_take && hdr_sent) || abort) begin
         buf_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         eom_bit <= 1'b0;
      else if ((good_take && tx_last) || abort || fin)
         eom_bit <= 1'b0;
      else if (end_wr)
         eom_bit <= 1'b1;
   end

   // R4: the end bit is consumed with the byte it marks
   p_eom_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (good_take && eom_bit) |=> !eom_bit);
   // R5: the last allowed payload byte closes the byte stream
   p_force_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (good_take && hdr_sent && pay_cnt == LAST_IDX) |=> state == ST_FINAL);
   // R6: an unserved request at load time ends the frame
   p_udr_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && hdr_sent && !buf_valid) |=> !busy);
   // R9: line events during a frame end it
   p_line_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && (arb_i || err_i)) |=> !busy);
   // R2: no byte is offered outside a frame
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !tx_avail);
endmodule

// File: rtl/txseq_top.sv
module txseq_top
   import txseq_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int MAX_PAYLOAD = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_wr,
   input  logic              end_wr,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_in,
   input  logic [ADDR_W-1:0] init_addr,
   input  logic [ADDR_W-1:0] dest_addr,
   input  logic [5:0]        flag_clr,
   input  logic [5:0]        irq_en,
   input  logic              bt_load,
   input  logic              bt_done,
   input  logic              bt_ack,
   input  logic              bt_arb_lost,
   input  logic              bt_err,
   output logic              tx_avail,
   output logic [DATA_W-1:0] tx_byte,
   output logic              tx_last,
   output logic              busy,
   output logic              eom_pending,
   output logic [5:0]        flags,
   output logic              irq
);
   logic [FLG_N-1:0] set_v;
   logic [FLG_N-1:0] clr_v;

   always_comb begin
      clr_v          = flag_clr;
      clr_v[FLG_REQ] = flag_clr[FLG_REQ] | data_wr;
   end

   txseq_fsm #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_PAYLOAD(MAX_PAYLOAD)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .start_wr(start_wr), .end_wr(end_wr), .data_wr(data_wr), .data_in(data_in),
      .init_addr(init_addr), .dest_addr(dest_addr),
      .load_i(bt_load), .done_i(bt_done), .ack_i(bt_ack),
      .arb_i(bt_arb_lost), .err_i(bt_err),
      .tx_avail(tx_avail), .tx_byte(tx_byte), .tx_last(tx_last),
      .busy(busy), .eom_o(eom_pending), .flag_set(set_v)
   );

   txseq_flag_bank #(.N(FLG_N)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_v), .clr_i(clr_v), .en_i(irq_en),
      .flag_o(flags), .irq_o(irq)
   );

   // R1: the first byte of a new frame is the packed header
   p_header_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (tx_avail && tx_byte == {init_addr, dest_addr}));
   // R7: completion is reported only when the frame is over
   p_end_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[FLG_END]) |-> !busy);
endmodule

// File: tb/txseq_top_bench.sv
module txseq_top_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_wr = 0, end_wr = 0, data_wr = 0;
   logic [7:0] data_in = 0;
   logic [3:0] init_addr = 0, dest_addr = 0;
   logic [5:0] flag_clr = 0, irq_en = 0;
   logic       bt_load = 0, bt_done = 0, bt_ack = 0, bt_arb_lost = 0, bt_err = 0;
   logic       tx_avail, tx_last, busy, eom_pending, irq;
   logic [7:0] tx_byte;
   logic [5:0] flags;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   txseq_top u_txseq_top (
      .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .end_wr(end_wr),
      .data_wr(data_wr), .data_in(data_in), .init_addr(init_addr),
      .dest_addr(dest_addr), .flag_clr(flag_clr), .irq_en(irq_en),
      .bt_load(bt_load), .bt_done(bt_done), .bt_ack(bt_ack),
      .bt_arb_lost(bt_arb_lost), .bt_err(bt_err), .tx_avail(tx_avail),
      .tx_byte(tx_byte), .tx_last(tx_last), .busy(busy),
      .eom_pending(eom_pending), .flags(flags), .irq(irq)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // each pulse: raised at a falling edge, dropped at the next one
   task automatic p_start();  start_wr = 1; @(negedge clk); start_wr = 0; endtask
   task automatic p_end();    end_wr = 1;   @(negedge clk); end_wr = 0;   endtask
   task automatic p_load();   bt_load = 1;  @(negedge clk); bt_load = 0;  endtask
   task automatic p_arb();    bt_arb_lost = 1; @(negedge clk); bt_arb_lost = 0; endtask
   task automatic p_err();    bt_err = 1;   @(negedge clk); bt_err = 0;   endtask
   task automatic p_done(input logic a);
      bt_done = 1; bt_ack = a; @(negedge clk); bt_done = 0; bt_ack = 0;
   endtask
   task automatic p_wr(input logic [7:0] d);
      data_wr = 1; data_in = d; @(negedge clk); data_wr = 0;
   endtask
   task automatic p_clr(input logic [5:0] m);
      flag_clr = m; @(negedge clk); flag_clr = 0;
   endtask

   function automatic logic [7:0] pay(input int len, input int k);
      return 8'((len * 17 + k * 3 + 5) & 8'hFF);
   endfunction

   // one full frame; eom_mode 1 sets the end bit on the final byte
   task automatic frame(input int len, input logic [3:0] ini, input logic [3:0] dst,
                        input bit use_eom, input logic ack);
      bit bcast;
      bcast = (dst == 4'hF);
      init_addr = ini; dest_addr = dst;
      if (len == 0) begin
         p_end();
         check("R4 end bit readback before ping", eom_pending, 1);
      end
      p_start();
      check("R2 busy after start", busy, 1);
      check("R1 header byte", tx_byte, {ini, dst});
      check("R1 header on offer", tx_avail, 1);
      check("R4 header final only for ping", tx_last, (len == 0));
      p_load();
      check("R3 request after header", flags[0], (len != 0));
      check("R4 end bit consumed", eom_pending, 0);
      p_done(ack);
      for (int k = 0; k < len; k++) begin
         p_wr(pay(len, k));
         check("R3 request cleared by write", flags[0], 0);
         if (use_eom && k == len - 1) p_end();
         check("R3 payload byte", tx_byte, pay(len, k));
         check("R4 R5 final marking", tx_last, (k == len - 1));
         p_load();
         check("R3 request after payload", flags[0], (k != len - 1));
         p_done(ack);
      end
      check("R7 completion flag", flags[1], 1);
      check("R7 busy cleared", busy, 0);
      check("R8 no nack flag", flags[4], 0);
      p_clr(6'h3F);
      check("R10 all flags cleared", flags, 0);
   endtask

   initial begin : main
      @(negedge clk);
      @(negedge clk);
      check("reset flags", flags, 0);
      check("reset busy", busy, 0);
      check("R2 reset no offer", tx_avail, 0);
      rst_n = 1;
      @(negedge clk);

      for (int len = 0; len <= 15; len++)
         frame(len, 4'(len ^ 5), 4'(len % 15), 1, 1'b1);
      frame(15, 4'h2, 4'h7, 0, 1'b1);   // R5: end bit never set
      frame(2, 4'h4, 4'hF, 1, 1'b0);    // R7: broadcast without ack
      frame(0, 4'h1, 4'hF, 1, 1'b0);

      // R8: missing ack on unicast header
      init_addr = 4'h3; dest_addr = 4'h3;
      p_start(); p_load(); p_done(1'b0);
      check("R8 nack flag", flags[4], 1);
      check("R8 busy cleared", busy, 0);
      check("R8 no completion", flags[1], 0);
      p_clr(6'h3F);

      // R8: missing ack on a payload byte
      p_start(); p_load(); p_done(1'b1); p_wr(8'h44); p_load(); p_done(1'b0);
      check("R8 nack on payload", flags[4], 1);
      check("R8 busy cleared payload", busy, 0);
      p_clr(6'h3F);

      // R6: underrun, with R10 interrupt gating
      irq_en = 6'b000100;
      p_start(); p_load(); p_done(1'b1);
      check("R6 no irq before underrun", irq, 0);
      p_load();
      check("R6 underrun flag", flags[2], 1);
      check("R6 busy cleared", busy, 0);
      check("R6 no completion", flags[1], 0);
      check("R10 irq enabled", irq, 1);
      irq_en = 6'b000010;
      @(negedge clk);
      check("R10 irq masked", irq, 0);
      p_clr(6'b000100);
      check("R10 single clear", flags, 6'b000001);
      p_clr(6'h3F);
      irq_en = 0;

      // R9: arbitration lost and transmit error
      p_start(); p_arb();
      check("R9 arb flag", flags[5], 1);
      check("R9 arb ends frame", busy, 0);
      p_clr(6'h3F);
      p_start(); p_load(); p_err();
      check("R9 err flag", flags[3], 1);
      check("R9 err ends frame", busy, 0);
      check("R9 err only", flags & 6'b110110, 6'b000000);
      p_clr(6'h3F);

      // R2: start while busy is ignored
      init_addr = 4'h6; dest_addr = 4'h9;
      p_start(); p_load();
      p_start();
      check("R2 busy kept", busy, 1);
      check("R2 header not reoffered", tx_avail, 0);
      p_wr(8'hC3);
      check("R2 payload offered not header", tx_byte, 8'hC3);
      p_end(); p_load(); p_done(1'b1);
      check("R2 frame still completes", flags[1], 1);
      p_clr(6'h3F);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule